// File: doc/BRIEF.md
# Flash ADC Conversion Sequencer

This block sits on the host side of an external 8-bit flash converter that has a parallel data bus. A single-cycle start request with a 3-bit channel number causes it to do several things in turn. It puts the channel on the address lines and pulses the active-low convert strobe. It then waits for the converter's active-low end-of-conversion line to fall, and reads the byte with chip select and read. The byte comes out with the channel tag and a one-cycle valid pulse. Every duration is a parameter counted in clock cycles.

The converter starts in a low-current sleep state. A rising edge on its wake line brings it to full power, so the sequencer sends one wake pulse after reset and waits a settling time before any conversion. When the converter runs with automatic power-down after each result, the requester raises `auto_pd_i` with the start request. The sequencer then sends a wake pulse ahead of that conversion. If the end-of-conversion edge never comes, a timeout pulse is raised and the sequencer goes back to idle. One start request that arrives while busy is held and is served after the current read.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst` is high and in the cycle after, `adc_convst_n_o`, `adc_cs_n_o` and `adc_rd_n_o` are high, `adc_wake_o` is low, and `res_valid_o` and `timeout_o` are low.
- R2: After reset is released, exactly one wake pulse is sent, high for WAKE_HIGH cycles. No convert strobe falls until at least WAKE_DELAY cycles after that pulse has ended.
- R3: Each accepted request drives `adc_convst_n_o` low for exactly CONV_LOW cycles. `adc_addr_o` carries the request's channel number (0 to 7) while the strobe is low.
- R4: After a falling edge on `adc_eoc_n_i`, which passes through a SYNC_STAGES-flop synchroniser, chip select falls. Read then stays low for RD_LOW cycles inside chip select. The byte on `adc_data_i` in the last read-low cycle appears on `res_data_o`, with the channel on `res_chan_o` and a one-cycle `res_valid_o`.
- R5: Chip select never falls earlier than MIN_CONV cycles after the convert strobe fell, even when end-of-conversion falls sooner.
- R6: If no end-of-conversion fall is detected within EOC_TIMEOUT cycles after the convert strobe returns high, `timeout_o` pulses for one cycle. No read takes place, no result is presented and the sequencer returns to idle.
- R7: Each conversion ends in exactly one of a result or a timeout. A later end-of-conversion edge never turns a timeout into a result, and an edge detected in the expiry cycle counts as a completion.
- R8: With `auto_pd_i` high at the start request, exactly one WAKE_HIGH-cycle wake pulse comes before that conversion's convert strobe. With it low, no wake pulse is sent.
- R9: One start request that arrives while busy is held and run after the current read ends. Results come out in request order, each with its own channel.
- R10: `res_valid_o` and `timeout_o` are each high for single cycles only and are never high together.
- R11: Read is low only while chip select is low. While chip select is low, the convert strobe stays high and the wake line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 3 | Channel number for the request |
| auto_pd_i | input | 1 | Send a wake pulse before this conversion |
| adc_addr_o | output | 3 | Channel address lines to the converter |
| adc_convst_n_o | output | 1 | Active-low convert-start strobe |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_rd_n_o | output | 1 | Active-low read strobe |
| adc_wake_o | output | 1 | Wake line, rising edge powers the converter up |
| adc_eoc_n_i | input | 1 | Active-low end of conversion, idles high |
| adc_data_i | input | 8 | Converter data bus |
| res_data_o | output | 8 | Captured result byte |
| res_chan_o | output | 3 | Channel tag of the result |
| res_valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle missing-end-of-conversion flag |

## Verification
Two events can land in the same cycle: the synchronised end-of-conversion edge and the expiry of the timeout counter. The bench provokes this by sweeping the converter model's response delay in single-cycle steps across a window centred on EOC_TIMEOUT. At every step it checks that exactly one of result and timeout appears. It also checks that the outcome switches from result to timeout only once across the sweep, with results at the low end and timeouts at the high end.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    ST_POR,
    ST_WAKE,
    ST_WAKE_WAIT,
    ST_IDLE,
    ST_ARM,
    ST_CONV,
    ST_WAIT_EOC,
    ST_SETUP,
    ST_READ,
    ST_HOLD
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/adc_seq_eoc_sync.sv
module adc_seq_eoc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc_n_i,
  output logic fall_o
);

  // STAGES synchroniser flops plus one history flop for the edge
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '1;
    else     sr_q <= {sr_q[STAGES-1:0], eoc_n_i};
  end

  assign fall_o = sr_q[STAGES] & ~sr_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= value_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 8,
  parameter int CONV_LOW    = 2,
  parameter int WAKE_HIGH   = 3,
  parameter int WAKE_DELAY  = 5,
  parameter int MIN_CONV    = 17,
  parameter int CS_SETUP    = 1,
  parameter int RD_LOW      = 2,
  parameter int CS_HOLD     = 1,
  parameter int EOC_TIMEOUT = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              auto_pd_i,
  output logic [CHAN_W-1:0] adc_addr_o,
  output logic              adc_convst_n_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o,
  output logic              adc_wake_o,
  input  logic              adc_eoc_n_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CHAN_W-1:0] res_chan_o,
  output logic              res_valid_o,
  output logic              timeout_o
);

  localparam int TMR_W = cnt_width(CONV_LOW + WAKE_HIGH + WAKE_DELAY + MIN_CONV +
                                   CS_SETUP + RD_LOW + CS_HOLD + EOC_TIMEOUT);

  seq_state_e        state_q, state_d;
  logic              tmr_zero, guard_zero, eoc_fall;
  logic [TMR_W-1:0]  tmr_value;
  logic              tmr_load, guard_load;
  logic              booting_q, eoc_seen_q, eoc_hit;
  logic              pend_q, pend_auto_q, act_auto_q;
  logic [CHAN_W-1:0] pend_chan_q, act_chan_q;
  logic              accept;

  adc_seq_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .eoc_n_i (adc_eoc_n_i),
    .fall_o  (eoc_fall)
  );

  // Phase timer: one count per state, reloaded on every state change
  adc_seq_timer #(.W(TMR_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tmr_load),
    .value_i (tmr_value),
    .zero_o  (tmr_zero)
  );

  // Guard timer: minimum conversion time, started with the convert strobe
  adc_seq_timer #(.W(TMR_W)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .load_i  (guard_load),
    .value_i (TMR_W'(MIN_CONV - 1)),
    .zero_o  (guard_zero)
  );

  assign eoc_hit = eoc_fall | eoc_seen_q;
  assign accept  = (state_q == ST_IDLE) && pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:       state_d = ST_WAKE;
      ST_WAKE:      if (tmr_zero) state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (tmr_zero) state_d = booting_q ? ST_IDLE : ST_CONV;
      ST_IDLE:      if (pend_q) state_d = ST_ARM;
      ST_ARM:       state_d = act_auto_q ? ST_WAKE : ST_CONV;
      ST_CONV:      if (tmr_zero) state_d = ST_WAIT_EOC;
      ST_WAIT_EOC: begin
        if (eoc_hit && guard_zero)  state_d = ST_SETUP;
        else if (!eoc_hit && tmr_zero) state_d = ST_IDLE;
      end
      ST_SETUP:     if (tmr_zero) state_d = ST_READ;
      ST_READ:      if (tmr_zero) state_d = ST_HOLD;
      ST_HOLD:      if (tmr_zero) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_WAKE:      tmr_value = TMR_W'(WAKE_HIGH - 1);
      ST_WAKE_WAIT: tmr_value = TMR_W'(WAKE_DELAY - 1);
      ST_CONV:      tmr_value = TMR_W'(CONV_LOW - 1);
      ST_WAIT_EOC:  tmr_value = TMR_W'(EOC_TIMEOUT - 1);
      ST_SETUP:     tmr_value = TMR_W'(CS_SETUP - 1);
      ST_READ:      tmr_value = TMR_W'(RD_LOW - 1);
      ST_HOLD:      tmr_value = TMR_W'(CS_HOLD - 1);
      default:      tmr_value = '0;
    endcase
  end

  assign tmr_load   = (state_d != state_q);
  assign guard_load = (state_d == ST_CONV) && (state_q != ST_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_POR;
      booting_q      <= 1'b1;
      eoc_seen_q     <= 1'b0;
      adc_convst_n_o <= 1'b1;
      adc_cs_n_o     <= 1'b1;
      adc_rd_n_o     <= 1'b1;
      adc_wake_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAKE_WAIT && tmr_zero) booting_q <= 1'b0;
      if (guard_load)
        eoc_seen_q <= 1'b0;
      else if (eoc_fall && (state_q == ST_CONV || state_q == ST_WAIT_EOC))
        eoc_seen_q <= 1'b1;
      adc_convst_n_o <= (state_d != ST_CONV);
      adc_cs_n_o     <= !(state_d == ST_SETUP || state_d == ST_READ || state_d == ST_HOLD);
      adc_rd_n_o     <= (state_d != ST_READ);
      adc_wake_o     <= (state_d == ST_WAKE);
    end
  end

  // One-deep request holding register and active request
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_chan_q <= '0;
      pend_auto_q <= 1'b0;
      act_chan_q  <= '0;
      act_auto_q  <= 1'b0;
    end else if (accept) begin
      act_chan_q  <= pend_chan_q;
      act_auto_q  <= pend_auto_q;
      pend_q      <= start_i;
      pend_chan_q <= chan_i;
      pend_auto_q <= auto_pd_i;
    end else if (start_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_chan_q <= chan_i;
      pend_auto_q <= auto_pd_i;
    end
  end

  assign adc_addr_o = act_chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data_o  <= '0;
      res_chan_o  <= '0;
      res_valid_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      if (state_q == ST_READ && tmr_zero) res_data_o <= adc_data_i;
      res_valid_o <= (state_q == ST_HOLD) && tmr_zero;
      if (state_q == ST_HOLD && tmr_zero) res_chan_o <= act_chan_q;
      timeout_o   <= (state_q == ST_WAIT_EOC) && tmr_zero && !eoc_hit;
    end
  end

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
  input logic clk,
  input logic rst,
  input logic convst_n,
  input logic cs_n,
  input logic rd_n,
  input logic wake,
  input logic res_valid,
  input logic timeout
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (convst_n && cs_n && rd_n && !wake && !res_valid && !timeout));

  assert_rd_inside_cs_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);

  assert_quiet_during_read_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (convst_n && !wake));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_timeout_single_R10: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, timeout}));

  assert_no_read_on_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (cs_n && rd_n));

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .convst_n  (adc_convst_n_o),
  .cs_n      (adc_cs_n_o),
  .rd_n      (adc_rd_n_o),
  .wake      (adc_wake_o),
  .res_valid (res_valid_o),
  .timeout   (timeout_o)
);

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;

  localparam int CONV_LOW    = 2;
  localparam int WAKE_HIGH   = 3;
  localparam int WAKE_DELAY  = 5;
  localparam int MIN_CONV    = 17;
  localparam int CS_SETUP    = 1;
  localparam int RD_LOW      = 2;
  localparam int CS_HOLD     = 1;
  localparam int EOC_TIMEOUT = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] chan_i = '0;
  logic       auto_pd_i = 1'b0;
  logic [2:0] adc_addr;
  logic       convst_n, cs_n, rd_n, wake;
  logic       eoc_n = 1'b1;
  logic [7:0] adc_data;
  logic [7:0] res_data;
  logic [2:0] res_chan;
  logic       res_valid, timeout;

  always #10 clk = ~clk;

  adc_conv_seq #(
    .CONV_LOW(CONV_LOW), .WAKE_HIGH(WAKE_HIGH), .WAKE_DELAY(WAKE_DELAY),
    .MIN_CONV(MIN_CONV), .CS_SETUP(CS_SETUP), .RD_LOW(RD_LOW),
    .CS_HOLD(CS_HOLD), .EOC_TIMEOUT(EOC_TIMEOUT)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .auto_pd_i(auto_pd_i),
    .adc_addr_o(adc_addr), .adc_convst_n_o(convst_n), .adc_cs_n_o(cs_n),
    .adc_rd_n_o(rd_n), .adc_wake_o(wake), .adc_eoc_n_i(eoc_n), .adc_data_i(adc_data),
    .res_data_o(res_data), .res_chan_o(res_chan), .res_valid_o(res_valid),
    .timeout_o(timeout)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit outcome_ok(input int v, input int t);
    return (v + t) == 1;
  endfunction

  // ---------------- converter model ----------------
  int         model_delay = 5;
  bit         model_mute = 1'b0;
  int         mcnt = -1;
  logic [7:0] model_byte = 8'h00;
  logic       m_convst_prev = 1'b1, m_rd_prev = 1'b1;

  always @(negedge clk) begin
    if (m_convst_prev && !convst_n) begin
      eoc_n <= 1'b1;
      mcnt  <= model_mute ? -1 : model_delay;
    end else if (mcnt > 0) begin
      mcnt <= mcnt - 1;
    end else if (mcnt == 0) begin
      eoc_n      <= 1'b0;
      model_byte <= 8'($urandom);
      mcnt       <= -1;
    end
    if (!m_rd_prev && rd_n) eoc_n <= 1'b1;
    m_convst_prev <= convst_n;
    m_rd_prev     <= rd_n;
  end

  assign adc_data = (!cs_n && !rd_n) ? model_byte : ~model_byte;

  // ---------------- monitor ----------------
  int   req_arr [0:255];
  int   wr_idx = 0, rd_idx = 0;
  int   n_valid = 0, n_timeout = 0;
  int   cl_run = 0, wh_run = 0, since_fall = 0, since_wake = 1000;
  int   wake_rises = 0;
  bit   overlap_bad = 1'b0;
  logic p_convst = 1'b1, p_wake = 1'b0, p_cs = 1'b1, p_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      since_fall++;
      since_wake++;
      if (!convst_n) cl_run++;
      if (wake) wh_run++;
      if (p_convst && !convst_n) begin
        since_fall = 0;
        check(adc_addr == 3'(req_arr[rd_idx]), "R3", "address at convert strobe",
              adc_addr, req_arr[rd_idx]);
        check(since_wake >= WAKE_DELAY, "R2", "wake settle before convert",
              since_wake, WAKE_DELAY);
      end
      if (!p_convst && convst_n) begin
        check(cl_run == CONV_LOW, "R3", "convert strobe low width", cl_run, CONV_LOW);
        cl_run = 0;
      end
      if (!p_wake && wake) wake_rises++;
      if (p_wake && !wake) begin
        check(wh_run == WAKE_HIGH, "R8", "wake pulse width", wh_run, WAKE_HIGH);
        wh_run = 0;
        since_wake = 0;
      end
      if (p_cs && !cs_n)
        check(since_fall >= MIN_CONV, "R5", "cycles convert-to-select", since_fall, MIN_CONV);
      if ((!rd_n && cs_n) || (!cs_n && (!convst_n || wake))) overlap_bad = 1'b1;
      if (res_valid) begin
        n_valid++;
        check(!p_valid, "R10", "valid pulse length", 2, 1);
        check(res_data == model_byte, "R4", "result byte", res_data, model_byte);
        check(res_chan == 3'(req_arr[rd_idx]), "R9", "result channel order",
              res_chan, req_arr[rd_idx]);
        rd_idx++;
      end
      if (timeout) begin
        n_timeout++;
        rd_idx++;
      end
      p_convst = convst_n;
      p_wake   = wake;
      p_cs     = cs_n;
      p_valid  = res_valid;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic request(input int ch, input bit ap);
    start_i   = 1'b1;
    chan_i    = 3'(ch);
    auto_pd_i = ap;
    req_arr[wr_idx] = ch;
    wr_idx++;
    @(negedge clk);
    start_i   = 1'b0;
    auto_pd_i = 1'b0;
  endtask

  task automatic wait_done(output int v, output int t);
    int v0 = n_valid;
    int t0 = n_timeout;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n_valid != v0 || n_timeout != t0) break;
    end
    repeat (2) @(negedge clk);
    v = n_valid - v0;
    t = n_timeout - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, t, w0;
    bit seen_to;
    int first_v, last_t;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    check(convst_n && cs_n && rd_n && !wake, "R1", "strobes idle in reset",
          {convst_n, cs_n, rd_n, wake}, 4'b1110);
    check(!res_valid && !timeout, "R1", "flags low in reset", {res_valid, timeout}, 0);
    rst = 1'b0;

    // request during boot: held until wake settles, then run (R2, R5 with early EOC)
    model_delay = 2;
    request(5, 1'b0);
    wait_done(v, t);
    check(wake_rises == 1, "R2", "boot wake pulses", wake_rises, 1);
    check(v == 1 && t == 0, "R4", "first conversion result", v, 1);

    // constrained random conversions (R4, R8)
    for (int k = 0; k < 24; k++) begin
      int ch = int'($urandom_range(7, 0));
      bit ap = 1'($urandom_range(1, 0));
      model_delay = int'($urandom_range(30, 1));
      w0 = wake_rises;
      request(ch, ap);
      wait_done(v, t);
      check(v == 1 && t == 0, "R4", "random conversion completes", v, 1);
      check(wake_rises - w0 == int'(ap), "R8", "wake pulses per conversion",
            wake_rises - w0, int'(ap));
      repeat (int'($urandom_range(3, 0))) @(negedge clk);
    end

    // silent converter: timeout (R6)
    model_mute = 1'b1;
    request(3, 1'b0);
    wait_done(v, t);
    check(t == 1 && v == 0, "R6", "timeout without end of conversion", t, 1);
    check(convst_n && cs_n && rd_n, "R6", "strobes idle after timeout",
          {convst_n, cs_n, rd_n}, 3'b111);
    model_mute = 1'b0;

    // sweep the EOC delay across the timeout expiry (R7)
    seen_to = 1'b0;
    first_v = 0;
    last_t  = 0;
    for (int d = EOC_TIMEOUT - 10; d <= EOC_TIMEOUT + 10; d++) begin
      model_delay = d;
      request(d % 8, 1'b0);
      wait_done(v, t);
      check(outcome_ok(v, t), "R7", "exactly one outcome per conversion", v + t, 1);
      if (seen_to) check(t == 1, "R7", "outcome order across sweep", v, 0);
      if (t == 1) seen_to = 1'b1;
      if (d == EOC_TIMEOUT - 10) first_v = v;
      if (d == EOC_TIMEOUT + 10) last_t = t;
      repeat (EOC_TIMEOUT) @(negedge clk);
    end
    check(first_v == 1, "R7", "short delay gives result", first_v, 1);
    check(last_t == 1, "R7", "long delay gives timeout", last_t, 1);

    // request while busy is held and served in order (R9)
    model_delay = 6;
    request(2, 1'b0);
    repeat (3) @(negedge clk);
    request(6, 1'b1);
    wait_done(v, t);
    check(v == 1, "R9", "first of two results", v, 1);
    wait_done(v, t);
    check(v == 1, "R9", "held request result", v, 1);
    check(rd_idx == wr_idx, "R9", "all requests answered", rd_idx, wr_idx);

    check(!overlap_bad, "R11", "strobe overlap seen", overlap_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule